// File: doc/BRIEF.md
# Masked Burst Write Path for a Graphics Memory Row

This block models the write side of one open row in one bank of a 32-bit-wide synchronous graphics memory. A write command captures its first data word on the same rising edge that registers the command. The burst then goes on, one word per clock, through a column sequence set by a burst-length code and an order flag, both captured with the command. A full-page burst walks the whole 256-column page, wraps from column 255 to column 0, and runs until a new read or write command arrives.

Every stored word is updated under two masks. The per-byte mask inputs come with each data word and can block any of its four bytes. A 32-bit bit-mask value, held outside this block, blocks single bits. It does so only while the row is flagged as opened with masked-write enable. The row contents can be read at any time through a combinational read-back port, which is used for checking.

Top module: `masked_burst_write`

## Requirements
- R1: When `wr_cmd` is high at a rising edge, `wdata` is written at that edge to column `col_addr`, under the masks of that cycle.
- R2: After the command, one further word per clock is written. For `burst_code` 1, 2 and 3 the burst holds 2, 4 and 8 words. With `interleave`=0, beat k goes to column (start with its low log2(L) bits replaced by (start+k) mod L), so it stays inside the aligned block of L columns.
- R3: With `interleave`=1 and a burst of 2, 4 or 8 words, beat k goes to column start XOR k.
- R4: When `byte_mask[b]`=1, bits 8b+7..8b of the addressed column keep their old value. When it is 0, they take the data, unless R5 blocks them.
- R5: When `masked_row`=1, a bit i with `bit_mask[i]`=0 keeps its old value. When `masked_row`=0, `bit_mask` has no effect.
- R6: Data presented after the last beat of a finite burst changes no column.
- R7: `burst_code`=7 selects a full-page burst. It ignores `interleave`, advances the column by one each clock modulo 256 (255 is followed by 0), and does not stop by itself.
- R8: A `rd_cmd` with `wr_cmd` low ends any burst in progress and writes nothing. A new `wr_cmd` ends the old burst and starts a new one. `wr_cmd` takes priority over `rd_cmd`.
- R9: `burst_code` and `interleave` are sampled only with `wr_cmd`. Changing them during a burst does not alter that burst.
- R10: While `rst_n` is low, all 256 columns are cleared to zero and no burst is active.
- R11: `burst_code` 0, 4, 5 and 6 give a single-word write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_cmd | input | 1 | Write command strobe |
| rd_cmd | input | 1 | Read command strobe (ends a burst only) |
| col_addr | input | 8 | Start column of a write command |
| wdata | input | 32 | Write data, one word per clock |
| byte_mask | input | 4 | Per-byte block, 1 = keep that byte |
| bit_mask | input | 32 | Per-bit enable, 0 = keep that bit |
| masked_row | input | 1 | Row was opened with masked-write enable |
| burst_code | input | 3 | Burst length code: 1/2/3 = 2/4/8 words, 7 = full page, else 1 |
| interleave | input | 1 | Burst order: 0 = sequential, 1 = interleaved |
| rd_col | input | 8 | Read-back column |
| rd_data | output | 32 | Contents of column `rd_col` |

## Verification
Every beat, including the command beat, lands in storage at the rising edge that samples it. Its effect is visible on `rd_data` straight after that edge, because the read-back port is combinational. The bench updates a behavioural model of the page at each rising edge from the same inputs. At the following falling edge, it sweeps `rd_col` over all 256 columns and compares each one. Inputs change only after that sweep, so each comparison covers exactly one edge's worth of writes, and stray writes anywhere in the page are caught in the cycle they occur.

// File: rtl/masked_burst_write.sv
module masked_burst_write #(
  parameter int COL_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_cmd,
  input  logic                rd_cmd,
  input  logic [COL_W-1:0]    col_addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] byte_mask,
  input  logic [DATA_W-1:0]   bit_mask,
  input  logic                masked_row,
  input  logic [2:0]          burst_code,
  input  logic                interleave,
  input  logic [COL_W-1:0]    rd_col,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int NCOL  = 1 << COL_W;
  localparam int NBYTE = DATA_W / 8;

  function automatic logic [COL_W-1:0] span_mask(input logic [2:0] code);
    case (code)
      3'd1:    return COL_W'(1);
      3'd2:    return COL_W'(3);
      3'd3:    return COL_W'(7);
      default: return '0;
    endcase
  endfunction

  logic [DATA_W-1:0] mem [NCOL];
  logic              active;
  logic [COL_W-1:0]  base, beat;
  logic [2:0]        code_q;
  logic              ilv_q;

  wire              full_q  = (code_q == 3'd7);
  wire [COL_W-1:0]  m_q     = span_mask(code_q);
  wire [COL_W-1:0]  seq_col = (base & ~m_q) | ((base + beat) & m_q);
  wire [COL_W-1:0]  bcol    = full_q ? base + beat : (ilv_q ? base ^ beat : seq_col);
  wire              beat_go = active & ~wr_cmd & ~rd_cmd;
  wire              do_wr   = wr_cmd | beat_go;
  wire [COL_W-1:0]  wcol    = wr_cmd ? col_addr : bcol;
  wire              last    = ~full_q && (beat == m_q);

  logic [DATA_W-1:0] wen;
  for (genvar b = 0; b < NBYTE; b++) begin : g_en
    assign wen[b*8 +: 8] = {8{~byte_mask[b]}} & (masked_row ? bit_mask[b*8 +: 8] : 8'hFF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCOL; c++) mem[c] <= '0;
      active <= 1'b0;
      base   <= '0;
      beat   <= '0;
      code_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      if (do_wr) mem[wcol] <= (mem[wcol] & ~wen) | (wdata & wen);
      if (wr_cmd) begin
        base   <= col_addr;
        beat   <= COL_W'(1);
        code_q <= burst_code;
        ilv_q  <= interleave;
        active <= (span_mask(burst_code) != '0) || (burst_code == 3'd7);
      end else if (rd_cmd) begin
        active <= 1'b0;
      end else if (active) begin
        beat <= beat + COL_W'(1);
        if (last) active <= 1'b0;
      end
    end
  end

  assign rd_data = mem[rd_col];

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (beat == COL_W'(1)) && (base == $past(col_addr)));
  p_beat_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_go |=> beat == COL_W'($past(beat) + COL_W'(1)));
  p_burst_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_go && last |=> !active);
  p_full_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_go && full_q |=> active);
  p_read_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd && !wr_cmd |=> !active);
  p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> $stable(code_q) && $stable(ilv_q));
endmodule

// File: tb/masked_burst_write_bench.sv
`timescale 1ns/1ps
module masked_burst_write_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_cmd = 0, rd_cmd = 0, masked_row = 0, interleave = 0;
  logic [7:0]  col_addr = 0, rd_col = 0;
  logic [31:0] wdata = 0, bit_mask = 32'hFFFF_FFFF;
  logic [3:0]  byte_mask = 0;
  logic [2:0]  burst_code = 0;
  logic [31:0] rd_data;

  int checks = 0, failures = 0, n = 0;
  string tag = "R10";
  logic [31:0] ref_mem [256];
  int q[$];
  bit full_mode = 0;

  always #10 clk = ~clk;

  masked_burst_write u_masked_burst_write (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .rd_cmd(rd_cmd), .col_addr(col_addr),
    .wdata(wdata), .byte_mask(byte_mask), .bit_mask(bit_mask), .masked_row(masked_row),
    .burst_code(burst_code), .interleave(interleave), .rd_col(rd_col), .rd_data(rd_data));

  task automatic put(input int c);
    for (int i = 0; i < 32; i++)
      if (!byte_mask[i/8] && (!masked_row || bit_mask[i])) ref_mem[c][i] = wdata[i];
  endtask

  task automatic model();
    if (!rst_n) begin
      for (int c = 0; c < 256; c++) ref_mem[c] = 0;
      q.delete(); full_mode = 0;
    end else if (wr_cmd) begin
      int a, len;
      a = col_addr; q.delete(); put(a);
      full_mode = (burst_code == 7);
      len = (burst_code >= 1 && burst_code <= 3) ? (1 << burst_code) : 1;
      if (full_mode) for (int k = 1; k < 256; k++) q.push_back((a + k) % 256);
      else for (int k = 1; k < len; k++)
        q.push_back(interleave ? (a ^ k) : (a / len) * len + (a % len + k) % len);
    end else if (rd_cmd) begin
      q.delete(); full_mode = 0;
    end else if (q.size() > 0) begin
      int c;
      c = q.pop_front(); put(c);
      if (full_mode && q.size() == 0)
        for (int k = 1; k <= 256; k++) q.push_back((c + k) % 256);
    end
  endtask

  task automatic sweep();
    bit bad = 0;
    for (int c = 0; c < 256; c++) begin
      rd_col = 8'(c);
      #0.01;
      if (rd_data !== ref_mem[c] && !bad) begin
        $display("FAIL %s col=%0d actual=%h expected=%h", tag, c, rd_data, ref_mem[c]);
        bad = 1;
      end
    end
    checks++;
    if (bad) failures++;
  endtask

  task automatic tick();
    @(posedge clk); model();
    @(negedge clk); sweep();
    n++; wdata = 32'h9E37_79B9 * n + 32'h0101_0101 * n;
    wr_cmd = 0; rd_cmd = 0;
  endtask

  task automatic cmd(input logic [7:0] a, input logic [2:0] code, input logic ilv);
    wr_cmd = 1; col_addr = a; burst_code = code; interleave = ilv;
    tick();
  endtask

  initial begin
    tag = "R10"; tick(); tick();
    rst_n = 1; tick();
    tag = "R1"; cmd(8'd6, 3'd2, 0);
    tag = "R2"; repeat (3) tick();
    tag = "R6"; repeat (3) tick();
    tag = "R2"; cmd(8'd13, 3'd3, 0); repeat (9) tick();
    tag = "R3"; cmd(8'h13, 3'd3, 1); repeat (8) tick();
    tag = "R3"; cmd(8'h42, 3'd1, 1); repeat (2) tick();
    tag = "R4"; byte_mask = 4'b0101; cmd(8'd6, 3'd2, 0);
    byte_mask = 4'b1010; tick(); byte_mask = 4'b1111; tick(); byte_mask = 4'b0000; tick();
    tag = "R5"; masked_row = 1; bit_mask = 32'h0F0F_33CC; cmd(8'd13, 3'd2, 1);
    byte_mask = 4'b0001; repeat (3) tick();
    tag = "R5"; masked_row = 0; byte_mask = 0; cmd(8'd14, 3'd0, 0); tick();
    masked_row = 1; bit_mask = 32'h0000_0000; cmd(8'd7, 3'd0, 0); tick();
    masked_row = 0; bit_mask = 32'hFFFF_FFFF;
    tag = "R11"; cmd(8'd100, 3'd4, 0); tick(); cmd(8'd101, 3'd5, 1); tick();
    cmd(8'd102, 3'd6, 0); tick(); cmd(8'd103, 3'd0, 0); tick();
    tag = "R7"; cmd(8'd250, 3'd7, 1); repeat (12) tick();
    tag = "R8"; rd_cmd = 1; tick(); repeat (3) tick();
    tag = "R8"; cmd(8'd30, 3'd7, 0); repeat (4) tick();
    cmd(8'd60, 3'd2, 0); repeat (4) tick();
    tag = "R8"; cmd(8'd80, 3'd3, 0); tick(); rd_cmd = 1; wr_cmd = 1; col_addr = 8'd90;
    burst_code = 3'd1; tick(); repeat (3) tick();
    tag = "R9"; cmd(8'd120, 3'd3, 0); burst_code = 3'd7; interleave = 1;
    repeat (9) tick();
    tag = "R9"; cmd(8'd140, 3'd1, 1); burst_code = 3'd3; repeat (4) tick();
    tag = "R7"; cmd(8'd0, 3'd7, 0); repeat (258) tick(); rd_cmd = 1; tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2ms;
    failures++;
    $display("FAIL watchdog %s actual=hung expected=done", tag);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule